// File: doc/BRIEF.md
# Mode-Steered DMA Byte Buffer Bridge

This block places a ten-byte buffer between a microcontroller's local bus and the DMA data port of a SCSI protocol chip. An 8-bit transfer-mode register, written by the microcontroller, decides which way bytes move. Each time the chip raises its byte request, exactly one byte moves, either from the chip into the buffer or from the buffer to the chip. The bridge then answers with a single-cycle acknowledge.

The microcontroller reaches the same storage in two ways. A single queue port pushes at the write index and pops at the read index. A ten-byte memory window reads and writes any cell directly and leaves both indices alone. The buffer tracks no occupancy. Both indices wrap modulo ten, and firmware is trusted to keep them consistent. When a chip transfer and a bus access fall in the same cycle, the transfer wins, and the bus master sees a wait signal and holds its strobe for one more cycle.

Top module: `dma_ring_bridge`

## Requirements
- R1: The buffer holds ten bytes. The read index and the write index each step by one per use and wrap from 9 to 0.
- R2: Synchronous reset sets both indices, the mode register, `dma_ack` and `lb_rdata` to zero. Buffer contents are not cleared.
- R3: With mode 0x80, a rising edge of `dma_req` stores `dma_din` at the write index and advances the write index. `dma_din` is sampled at the second clock edge after the request is first seen high.
- R4: With mode 0x90, a rising edge of `dma_req` places the byte at the read index on `dma_dout` during the acknowledge cycle and advances the read index.
- R5: `dma_ack` is high for exactly one cycle, from the second clock edge after the request is first sampled high. A request held high for many cycles causes only one transfer.
- R6: With any mode value other than 0x80 or 0x90, a request produces no transfer, no acknowledge and no index change.
- R7: At the queue port address 0x2C, a bus write stores `lb_wdata` at the write index and advances it. A bus read returns the byte at the read index on `lb_rdata` one cycle later and advances the read index.
- R8: Addresses 0x40 to 0x49 map buffer cells 0 to 9. Reads and writes there move neither index.
- R9: The mode register is write-only at address 0x02. Reads of 0x02, and reads outside the port and the window (for example 0x3F and 0x4A), return 0x00.
- R10: In the cycle a transfer fires, `lb_wait` is high and any bus access is ignored. The master holds it, and it completes after the transfer, so the transfer's byte comes first in the buffer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_addr | input | 8 | Local bus address |
| lb_wdata | input | 8 | Local bus write data |
| lb_wr | input | 1 | Local bus write strobe (wins over `lb_rd`) |
| lb_rd | input | 1 | Local bus read strobe |
| lb_rdata | output | 8 | Read data, valid the cycle after an accepted read |
| lb_wait | output | 1 | Bus access not accepted this cycle; hold the strobe |
| dma_req | input | 1 | Byte request from the SCSI chip |
| dma_din | input | 8 | Byte from the chip (chip-to-buffer mode) |
| dma_dout | output | 8 | Byte to the chip, valid while `dma_ack` is high |
| dma_ack | output | 1 | One-cycle byte acknowledge to the chip |

## Verification
The bench sweeps all 256 mode codes, one request per code. A design that decoded a single direction bit would answer codes such as 0x81 or 0x10 and shift the indices, and the final dump of the window exposes that. Pushes and pops run past the tenth byte, where a power-of-two wrap would land on a phantom eleventh cell and return stale data. A request held high for several cycles catches level-sensitive triggering, which would produce a burst of acknowledges. Collisions between a transfer and a port access, in both directions, catch a design that drops the stalled access or puts it ahead of the chip's byte.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  // transfer direction codes held in the mode register
  typedef enum logic [7:0] {
    XFER_CHIP_TO_BUF = 8'h80,
    XFER_BUF_TO_CHIP = 8'h90
  } xfer_mode_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 10,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R1: index never leaves the ten cells
  p_range_r1: assert property (@(posedge clk) disable iff (rst) idx <= LAST);
  // R1: wrap from last cell to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && idx == LAST) |=> idx == '0);
  // R1: ordinary step is plus one
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && idx != LAST) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/buf_ram.sv
module buf_ram #(
  parameter int DEPTH = 10,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  // single-port, read-before-write, registered output
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dma_req,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  output logic       mode_ok,
  output logic       to_buf,
  output logic       fire,
  output logic       dma_ack
);
  logic [7:0] mode_q;
  logic       req_q, req_qq;
  logic       hit_in, hit_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      req_q   <= 1'b0;
      req_qq  <= 1'b0;
      dma_ack <= 1'b0;
    end else begin
      req_q   <= dma_req;
      req_qq  <= req_q;
      dma_ack <= fire;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  assign hit_in  = (mode_q == XFER_CHIP_TO_BUF);
  assign hit_out = (mode_q == XFER_BUF_TO_CHIP);
  assign mode_ok = hit_in | hit_out;
  assign to_buf  = hit_in;
  assign fire    = req_q & ~req_qq & mode_ok;

  // R5: acknowledge lasts a single cycle
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    dma_ack |=> !dma_ack);
  // R5: acknowledge only follows a request seen two edges earlier
  p_ack_req_r5: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> $past(dma_req, 2));
  // R5: no two transfers on back-to-back cycles
  p_fire_gap_r5: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/dma_ring_bridge.sv
module dma_ring_bridge
  import dma_ring_pkg::*;
#(
  parameter int                  DEPTH     = 10,
  parameter int                  ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]   MODE_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0]   PORT_ADDR = 8'h2C,
  parameter logic [ADDR_W-1:0]   WIN_BASE  = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [7:0]        lb_wdata,
  input  logic              lb_wr,
  input  logic              lb_rd,
  output logic [7:0]        lb_rdata,
  output logic              lb_wait,
  input  logic              dma_req,
  input  logic [7:0]        dma_din,
  output logic [7:0]        dma_dout,
  output logic              dma_ack
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              fire, to_buf, mode_ok;
  logic              bus_go, sel_port, sel_mode, sel_win;
  logic [ADDR_W-1:0] win_off;
  logic              port_wr, port_rd, win_acc, mode_we;
  logic              wr_adv, rd_adv;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              ram_en, ram_we;
  logic [IDX_W-1:0]  ram_addr;
  logic [7:0]        ram_wdata, ram_q;
  logic              hit_q;

  // bus decode; a firing transfer blocks the bus for that cycle
  assign bus_go   = (lb_wr | lb_rd) & ~fire;
  assign sel_port = (lb_addr == PORT_ADDR);
  assign sel_mode = (lb_addr == MODE_ADDR);
  assign win_off  = lb_addr - WIN_BASE;
  assign sel_win  = (lb_addr >= WIN_BASE) && (win_off < ADDR_W'(DEPTH));

  assign port_wr = bus_go & lb_wr & sel_port;
  assign port_rd = bus_go & ~lb_wr & lb_rd & sel_port;
  assign win_acc = bus_go & sel_win;
  assign mode_we = bus_go & lb_wr & sel_mode;

  assign wr_adv = (fire & to_buf) | port_wr;
  assign rd_adv = (fire & ~to_buf) | port_rd;

  dma_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .dma_req    (dma_req),
    .mode_we    (mode_we),
    .mode_wdata (lb_wdata),
    .mode_ok    (mode_ok),
    .to_buf     (to_buf),
    .fire       (fire),
    .dma_ack    (dma_ack)
  );

  ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr_ptr (
    .clk (clk), .rst (rst), .adv (wr_adv), .idx (wr_idx)
  );

  ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd_ptr (
    .clk (clk), .rst (rst), .adv (rd_adv), .idx (rd_idx)
  );

  // one storage port, shared by priority: transfer, queue port, window
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = wr_idx;
    ram_wdata = lb_wdata;
    if (fire) begin
      ram_en = 1'b1;
      if (to_buf) begin
        ram_we    = 1'b1;
        ram_wdata = dma_din;
      end else begin
        ram_addr = rd_idx;
      end
    end else if (port_wr) begin
      ram_en = 1'b1;
      ram_we = 1'b1;
    end else if (port_rd) begin
      ram_en   = 1'b1;
      ram_addr = rd_idx;
    end else if (win_acc) begin
      ram_en   = 1'b1;
      ram_we   = lb_wr;
      ram_addr = win_off[IDX_W-1:0];
    end
  end

  buf_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= bus_go & ~lb_wr & lb_rd & (sel_port | sel_win);
  end

  assign lb_rdata = hit_q ? ram_q : 8'h00;
  assign lb_wait  = fire;
  assign dma_dout = ram_q;

  // R6: an unrecognised mode leaves the indices to the bus alone
  p_ignore_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && !port_wr) |=> $stable(wr_idx));
  p_ignore_rd_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && !port_rd) |=> $stable(rd_idx));
  // R8: window accesses move no index
  p_window_r8: assert property (@(posedge clk) disable iff (rst)
    win_acc |=> ($stable(wr_idx) && $stable(rd_idx)));
  // R10: a stalled bus read returns nothing the next cycle
  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !hit_q);
  // R10: a chip-to-buffer transfer keeps a colliding port pop from moving the read index
  p_stall_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && to_buf) |=> $stable(rd_idx));
endmodule

// File: tb/dma_ring_bridge_test.sv
module dma_ring_bridge_test;
  localparam logic [7:0] A_MODE = 8'h02;
  localparam logic [7:0] A_PORT = 8'h2C;
  localparam logic [7:0] A_WIN  = 8'h40;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] lb_addr, lb_wdata, lb_rdata, dma_din, dma_dout;
  logic       lb_wr, lb_rd, lb_wait, dma_req, dma_ack;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [7:0] m_mem [10];
  int e_wr = 0;
  int e_rd = 0;

  always #5 clk = ~clk;

  dma_ring_bridge uut (
    .clk (clk), .rst (rst),
    .lb_addr (lb_addr), .lb_wdata (lb_wdata), .lb_wr (lb_wr), .lb_rd (lb_rd),
    .lb_rdata (lb_rdata), .lb_wait (lb_wait),
    .dma_req (dma_req), .dma_din (dma_din), .dma_dout (dma_dout), .dma_ack (dma_ack)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    lb_addr = a; lb_wdata = d; lb_wr = 1'b1;
    while (lb_wait) @(negedge clk);
    @(negedge clk);
    lb_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    lb_addr = a; lb_rd = 1'b1;
    while (lb_wait) @(negedge clk);
    @(negedge clk);
    lb_rd = 1'b0;
    d = lb_rdata;
  endtask

  task automatic dma_pulse(input logic [7:0] din, output logic ack_seen,
                           output logic [7:0] dout, output logic ack_after);
    dma_req = 1'b1; dma_din = din;
    @(negedge clk);
    dma_req = 1'b0;
    @(negedge clk);
    ack_seen = dma_ack; dout = dma_dout;
    @(negedge clk);
    ack_after = dma_ack;
  endtask

  task automatic dump_window(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 10; i++) begin
      bus_rd(A_WIN + 8'(i), d);
      check(tag, d, m_mem[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, dout;
    logic       ack, ack2;
    int         acks;

    rst = 1'b1; lb_addr = '0; lb_wdata = '0; lb_wr = 1'b0; lb_rd = 1'b0;
    dma_req = 1'b0; dma_din = '0;
    repeat (3) @(negedge clk);
    check("R2 rdata at reset", lb_rdata, 8'h00);
    check("R2 ack at reset", {7'b0, dma_ack}, 8'h00);
    check("R10 wait at reset", {7'b0, lb_wait}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    // R8: fill and read back window
    for (int i = 0; i < 10; i++) begin
      m_mem[i] = 8'(i * 23 + 5);
      bus_wr(A_WIN + 8'(i), m_mem[i]);
    end
    dump_window("R8 window readback");
    // R2/R7: read index still at cell 0 after window traffic
    bus_rd(A_PORT, d);
    check("R2 R7 first port pop from cell 0", d, m_mem[0]);
    e_rd = 1;

    // R7/R1: push past the end, wrap
    for (int i = 0; i < 13; i++) begin
      bus_wr(A_PORT, 8'hA0 + 8'(i));
      m_mem[e_wr] = 8'hA0 + 8'(i);
      e_wr = (e_wr + 1) % 10;
    end
    dump_window("R1 R7 push wrap");
    for (int i = 0; i < 12; i++) begin
      bus_rd(A_PORT, d);
      check("R1 R7 pop wrap", d, m_mem[e_rd]);
      e_rd = (e_rd + 1) % 10;
    end

    // R9: write-only mode and unmapped reads
    bus_wr(A_MODE, 8'h90);
    bus_rd(A_MODE, d);
    check("R9 mode read", d, 8'h00);
    bus_rd(8'h4A, d);
    check("R9 above window", d, 8'h00);
    bus_rd(8'h3F, d);
    check("R9 below window", d, 8'h00);

    // R3/R4/R6: every mode code
    for (int m = 0; m < 256; m++) begin
      bus_wr(A_MODE, 8'(m));
      dma_pulse(8'(m) ^ 8'h5A, ack, dout, ack2);
      check("R5 ack width", {7'b0, ack2}, 8'h00);
      if (m == 8'h80) begin
        check("R3 ack", {7'b0, ack}, 8'h01);
        m_mem[e_wr] = 8'(m) ^ 8'h5A;
        e_wr = (e_wr + 1) % 10;
      end else if (m == 8'h90) begin
        check("R4 ack", {7'b0, ack}, 8'h01);
        check("R4 dout", dout, m_mem[e_rd]);
        e_rd = (e_rd + 1) % 10;
      end else begin
        check("R6 no ack", {7'b0, ack}, 8'h00);
      end
    end
    dump_window("R3 R6 after mode sweep");
    bus_rd(A_PORT, d);
    check("R4 R6 read index after sweep", d, m_mem[e_rd]);
    e_rd = (e_rd + 1) % 10;

    // R3: several back-to-back chip-to-buffer bytes with wrap
    bus_wr(A_MODE, 8'h80);
    for (int i = 0; i < 11; i++) begin
      dma_pulse(8'h30 + 8'(i), ack, dout, ack2);
      check("R3 burst ack", {7'b0, ack}, 8'h01);
      m_mem[e_wr] = 8'h30 + 8'(i);
      e_wr = (e_wr + 1) % 10;
    end
    dump_window("R3 burst store");

    // R4: buffer-to-chip run with wrap
    bus_wr(A_MODE, 8'h90);
    for (int i = 0; i < 11; i++) begin
      dma_pulse(8'h00, ack, dout, ack2);
      check("R4 burst dout", dout, m_mem[e_rd]);
      e_rd = (e_rd + 1) % 10;
    end

    // R5: held request gives one transfer
    bus_wr(A_MODE, 8'h80);
    acks = 0;
    dma_din = 8'h5E; dma_req = 1'b1;
    repeat (6) begin @(negedge clk); if (dma_ack) acks++; end
    dma_req = 1'b0;
    repeat (3) begin @(negedge clk); if (dma_ack) acks++; end
    check("R5 held request acks", 8'(acks), 8'h01);
    m_mem[e_wr] = 8'h5E;
    e_wr = (e_wr + 1) % 10;
    dump_window("R5 held request store");

    // R10: collision, chip-to-buffer vs port push
    dma_req = 1'b1; dma_din = 8'h3C;
    @(negedge clk);
    dma_req = 1'b0;
    check("R10 wait in transfer cycle", {7'b0, lb_wait}, 8'h01);
    lb_addr = A_PORT; lb_wdata = 8'hE7; lb_wr = 1'b1;
    @(negedge clk);
    check("R5 ack during stall", {7'b0, dma_ack}, 8'h01);
    check("R10 wait released", {7'b0, lb_wait}, 8'h00);
    @(negedge clk);
    lb_wr = 1'b0;
    m_mem[e_wr] = 8'h3C; e_wr = (e_wr + 1) % 10;
    m_mem[e_wr] = 8'hE7; e_wr = (e_wr + 1) % 10;
    dump_window("R10 push order");

    // R10: collision, buffer-to-chip vs port pop
    bus_wr(A_MODE, 8'h90);
    dma_req = 1'b1;
    @(negedge clk);
    dma_req = 1'b0;
    check("R10 wait on pop collision", {7'b0, lb_wait}, 8'h01);
    lb_addr = A_PORT; lb_rd = 1'b1;
    @(negedge clk);
    check("R10 chip byte first", dma_dout, m_mem[e_rd]);
    e_rd = (e_rd + 1) % 10;
    @(negedge clk);
    lb_rd = 1'b0;
    check("R10 stalled pop gets next", lb_rdata, m_mem[e_rd]);
    e_rd = (e_rd + 1) % 10;

    // R2: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    e_wr = 0; e_rd = 0;
    dma_pulse(8'h77, ack, dout, ack2);
    check("R2 mode cleared", {7'b0, ack}, 8'h00);
    bus_rd(A_PORT, d);
    check("R2 read index cleared", d, m_mem[0]);
    bus_wr(A_PORT, 8'h99);
    m_mem[0] = 8'h99;
    bus_rd(A_WIN, d);
    check("R2 write index cleared", d, 8'h99);
    bus_rd(A_WIN + 8'd1, d);
    check("R2 contents kept", d, m_mem[1]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule